// File: doc/BRIEF.md
# Voltage Regulator Soft-Start Sequencer

This block sequences the start-up of a buck regulator. It receives digital flags that are already qualified: bias supply good, driver supply good and enable. It also receives a mode select, a 6-bit voltage identification (VID) bus and a tick from the soft-start oscillator. From these it drives a reference code to the regulator's DAC, in steps of 6.25 mV per code. It also drives the enables for the upper and lower gate drivers, a power-good flag, a fault flag and the current sequencing state.

Start-up has two ramps. The first ramp moves the reference up, one code per oscillator tick, to a fixed boot level. The reference then holds at that level for a timed window. The VID bus is read at the end of the window. A second ramp then moves the reference up or down to the requested target. One mode adds a fixed delay before the first ramp. Another mode uses a 5-bit VID, in which the all-ones code means no load and blocks start-up. Losing any supply or enable flag returns the block to shutdown at once.

Top module: `vr_softstart_seq`

## Requirements
- R1: In shutdown (state_o = 0), both gate enables are low, the reference code is 0, and pgood_o and fault_o are low. Reset places the block in shutdown.
- R2: The block leaves shutdown only when bias_ok_i, drv_ok_i and en_i are all high in the same cycle. The new state appears after the next clock edge.
- R3: In 5-bit mode (mode_i = 2'b10), the block stays in shutdown while vid_i[4:0] = 5'b11111, even when all three flags are high.
- R4: In delayed mode (mode_i = 2'b00), start-up first enters the delay state (state_o = 1) for DLY_CYCLES cycles with the reference at 0. Every other mode goes straight to the first ramp (state_o = 2).
- R5: During either ramp, each cycle with ss_tick_i high changes the reference by exactly one code in the direction of its goal. Cycles without a tick leave the reference unchanged.
- R6: The first ramp ends when the reference reaches BOOT_CODE (default 176, which is 1.1 V). The block then holds (state_o = 3) for HOLD_CYCLES cycles at BOOT_CODE, and ticks are ignored during the hold.
- R7: VID is sampled in the last hold cycle. The effective code is vid_i[5:0], or vid_i[4:0] in 5-bit mode. The target is the effective code times 4. The code is valid if it is nonzero and is not the 5-bit all-ones value. A valid code starts the second ramp (state_o = 4), which counts up or down toward the target.
- R8: An invalid VID moves the block to fault (state_o = 6). In fault, the reference stays at BOOT_CODE, fault_o is high and pgood_o stays low.
- R9: pgood_o rises one cycle after the reference first equals the target in the second ramp (state_o = 5). It then stays high and the reference stays constant.
- R10: If any of the three flags is low in any state, the next edge returns the block to shutdown with the reference at 0 and pgood_o and fault_o low. This takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bias_ok_i | input | 1 | Bias supply above its power-on threshold |
| drv_ok_i | input | 1 | Driver supply above its power-on threshold |
| en_i | input | 1 | Enable input above its threshold |
| mode_i | input | 2 | 00 delayed, 01 6-bit, 10 5-bit, 11 treated as 6-bit |
| vid_i | input | 6 | Voltage identification code |
| ss_tick_i | input | 1 | Soft-start oscillator tick, one step per high cycle |
| ref_code_o | output | 8 | DAC reference code, 6.25 mV per LSB |
| ugate_en_o | output | 1 | Upper gate drive enable |
| lgate_en_o | output | 1 | Lower gate drive enable |
| pgood_o | output | 1 | Power good |
| fault_o | output | 1 | Invalid VID at sample time |
| state_o | output | 3 | Sequencing state code |

## Verification
Two functions can act in the same cycle: a ramp step triggered by an oscillator tick, and the abort caused by a flag dropping. The bench raises ss_tick_i and lowers bias_ok_i together partway up a ramp. It then requires the next sample to show shutdown with a zero reference, not a reference one code higher. The hold window gives a second overlap, since ticks keep arriving while the VID is being sampled. The bench checks that these ticks neither move the reference nor change which sample decides the target.

// File: rtl/vrss_pkg.sv
package vrss_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_DELAY = 3'd1,
    ST_RAMP1 = 3'd2,
    ST_HOLD  = 3'd3,
    ST_RAMP2 = 3'd4,
    ST_DONE  = 3'd5,
    ST_FAULT = 3'd6
  } vrss_state_e;

  typedef enum logic [1:0] {
    MODE_DELAYED = 2'b00,
    MODE_BIT6    = 2'b01,
    MODE_BIT5    = 2'b10,
    MODE_RSVD    = 2'b11
  } vrss_mode_e;

endpackage

// File: rtl/vrss_vid_decode.sv
module vrss_vid_decode #(
  parameter int VID_W     = 6,
  parameter int CODE_W    = 8,
  parameter int TGT_SHIFT = 2
) (
  input  logic [1:0]        mode_i,
  input  logic [VID_W-1:0]  vid_i,
  output logic [CODE_W-1:0] tgt_o,
  output logic              valid_o,
  output logic              no_load_o
);
  import vrss_pkg::*;

  logic             short_mode;
  logic [VID_W-1:0] vid_eff;

  assign short_mode = (mode_i == MODE_BIT5);
  assign vid_eff    = short_mode ? {1'b0, vid_i[VID_W-2:0]} : vid_i;
  assign no_load_o  = short_mode && (&vid_i[VID_W-2:0]);
  assign valid_o    = (vid_eff != '0) && !no_load_o;
  assign tgt_o      = CODE_W'({{(CODE_W-VID_W){1'b0}}, vid_eff} << TGT_SHIFT);

endmodule

// File: rtl/vrss_period_timer.sv
module vrss_period_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  assign done_o = run_i && (cnt_q == len_i - CNT_W'(1));

  // a fresh window always starts from zero
  assert_window_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> cnt_q == '0);

endmodule

// File: rtl/vrss_ref_stepper.sv
module vrss_ref_stepper #(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              up_i,
  output logic [CODE_W-1:0] ref_o
);

  logic [CODE_W-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ref_q <= '0;
    else if (clr_i)  ref_q <= '0;
    else if (step_i) ref_q <= up_i ? ref_q + CODE_W'(1) : ref_q - CODE_W'(1);
  end

  assign ref_o = ref_q;

  assert_idle_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !step_i |=> $stable(ref_q));

  assert_step_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && step_i && up_i |=> ref_q == $past(ref_q) + CODE_W'(1));

  assert_step_dn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && step_i && !up_i |=> ref_q == $past(ref_q) - CODE_W'(1));

endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq #(
  parameter int VID_W       = 6,
  parameter int CODE_W      = 8,
  parameter int TGT_SHIFT   = 2,
  parameter int BOOT_CODE   = 176,
  parameter int DLY_CYCLES  = 1100,
  parameter int HOLD_CYCLES = 93
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bias_ok_i,
  input  logic              drv_ok_i,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic [VID_W-1:0]  vid_i,
  input  logic              ss_tick_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              ugate_en_o,
  output logic              lgate_en_o,
  output logic              pgood_o,
  output logic              fault_o,
  output logic [2:0]        state_o
);
  import vrss_pkg::*;

  localparam int MAX_WIN = (DLY_CYCLES > HOLD_CYCLES) ? DLY_CYCLES : HOLD_CYCLES;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);
  localparam logic [CODE_W-1:0] BOOT    = CODE_W'(BOOT_CODE);
  localparam logic [CODE_W-1:0] BOOT_M1 = CODE_W'(BOOT_CODE - 1);
  localparam logic [CNT_W-1:0]  DLY_LEN  = CNT_W'(DLY_CYCLES);
  localparam logic [CNT_W-1:0]  HOLD_LEN = CNT_W'(HOLD_CYCLES);

  vrss_state_e       state_q, state_d;
  logic [CODE_W-1:0] tgt_q, vid_tgt, ref_q;
  logic              pwr_ok, vid_valid, no_load;
  logic              tmr_run, tmr_done;
  logic [CNT_W-1:0]  tmr_len;
  logic              step_en, step_up, ref_clr, tgt_ld;

  assign pwr_ok = bias_ok_i && drv_ok_i && en_i;

  vrss_vid_decode #(
    .VID_W(VID_W), .CODE_W(CODE_W), .TGT_SHIFT(TGT_SHIFT)
  ) u_vid (
    .mode_i   (mode_i),
    .vid_i    (vid_i),
    .tgt_o    (vid_tgt),
    .valid_o  (vid_valid),
    .no_load_o(no_load)
  );

  assign tmr_run = pwr_ok && (state_q == ST_DELAY || state_q == ST_HOLD);
  assign tmr_len = (state_q == ST_DELAY) ? DLY_LEN : HOLD_LEN;

  vrss_period_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (tmr_run),
    .len_i (tmr_len),
    .done_o(tmr_done)
  );

  assign step_en = ss_tick_i && pwr_ok &&
                   (state_q == ST_RAMP1 || (state_q == ST_RAMP2 && ref_q != tgt_q));
  assign step_up = (state_q == ST_RAMP1) || (tgt_q > ref_q);
  assign ref_clr = !pwr_ok || state_q == ST_OFF;

  vrss_ref_stepper #(.CODE_W(CODE_W)) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ref_clr),
    .step_i(step_en),
    .up_i  (step_up),
    .ref_o (ref_q)
  );

  always_comb begin
    state_d = state_q;
    tgt_ld  = 1'b0;
    if (!pwr_ok) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:   if (!no_load) state_d = (mode_i == MODE_DELAYED) ? ST_DELAY : ST_RAMP1;
        ST_DELAY: if (tmr_done) state_d = ST_RAMP1;
        ST_RAMP1: if (step_en && ref_q == BOOT_M1) state_d = ST_HOLD;
        ST_HOLD:  if (tmr_done) begin
                    state_d = vid_valid ? ST_RAMP2 : ST_FAULT;
                    tgt_ld  = vid_valid;
                  end
        ST_RAMP2: if (ref_q == tgt_q) state_d = ST_DONE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (tgt_ld) tgt_q <= vid_tgt;
    end
  end

  assign ref_code_o = ref_q;
  assign ugate_en_o = (state_q != ST_OFF);
  assign lgate_en_o = (state_q != ST_OFF);
  assign pgood_o    = (state_q == ST_DONE);
  assign fault_o    = (state_q == ST_FAULT);
  assign state_o    = state_q;

  assert_off_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_OFF |-> ref_q == '0 && !ugate_en_o && !lgate_en_o && !pgood_o);

  assert_flags_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_OFF && !pwr_ok |=> state_q == ST_OFF);

  assert_noload_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_OFF && no_load |=> state_q == ST_OFF);

  assert_delay_at_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DELAY |-> ref_q == '0);

  assert_hold_at_boot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HOLD |-> ref_q == BOOT);

  assert_fault_at_boot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FAULT |-> ref_q == BOOT && !pgood_o);

  assert_pgood_at_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o |-> ref_q == tgt_q);

  assert_pgood_late_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgood_o) |-> $past(state_q) == ST_RAMP2 && $past(ref_q) == tgt_q);

  assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok |=> state_q == ST_OFF && ref_q == '0 && !pgood_o && !fault_o);

endmodule

// File: tb/vr_softstart_seq_tb_top.sv
module vr_softstart_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DLY  = 50;
  localparam int HOLD = 20;
  localparam int BOOT = 176;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bias_ok = 1'b0, drv_ok = 1'b0, en = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [5:0] vid = 6'd0;
  logic       tick = 1'b0;
  logic [7:0] ref_code;
  logic       ugate_en, lgate_en, pgood, fault;
  logic [2:0] state;

  int n_vec = 0;
  int n_bad = 0;
  int exp_ref = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vr_softstart_seq #(
    .DLY_CYCLES(DLY), .HOLD_CYCLES(HOLD), .BOOT_CODE(BOOT)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bias_ok_i(bias_ok), .drv_ok_i(drv_ok), .en_i(en),
    .mode_i(mode), .vid_i(vid), .ss_tick_i(tick), .ref_code_o(ref_code),
    .ugate_en_o(ugate_en), .lgate_en_o(lgate_en), .pgood_o(pgood), .fault_o(fault),
    .state_o(state)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic flags(input logic b, input logic d, input logic e);
    bias_ok = b; drv_ok = d; en = e;
  endtask

  // n ticks, each followed by an idle cycle; exp_ref tracks the reference
  task automatic ramp_ticks(input int n, input bit up, input string req);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc();
      exp_ref = up ? exp_ref + 1 : exp_ref - 1;
      check(req, ref_code, exp_ref);
      tick = 1'b0;
      cyc();
      check(req, ref_code, exp_ref);
    end
  endtask

  // finishes ramp 1 from the current reference and runs the hold window
  task automatic ramp1_and_hold(input int final_state);
    ramp_ticks(BOOT - 1 - exp_ref, 1'b1, "R5 ramp1 step");
    tick = 1'b1;
    cyc();
    exp_ref = BOOT;
    check("R6 boot level", ref_code, BOOT);
    check("R6 enter hold", state, 3);
    tick = 1'b0;
    cyc();
    for (int i = 3; i <= HOLD; i++) begin
      tick = (i % 2 == 0);
      cyc();
      check("R6 hold state", state, 3);
      check("R6 ticks ignored in hold", ref_code, BOOT);
    end
    tick = 1'b0;
    cyc();
    check("R7 after hold", state, final_state);
  endtask

  task automatic ramp2_to(input int tgt);
    int n = (tgt > exp_ref) ? tgt - exp_ref : exp_ref - tgt;
    bit up = (tgt > exp_ref);
    ramp_ticks(n - 1, up, "R5 ramp2 step");
    tick = 1'b1;
    cyc();
    exp_ref = tgt;
    check("R9 target reached", ref_code, tgt);
    check("R9 pgood one cycle late", pgood, 0);
    tick = 1'b0;
    cyc();
    check("R9 pgood high", pgood, 1);
    check("R9 done state", state, 5);
    tick = 1'b1;
    cyc();
    tick = 1'b0;
    check("R9 reference frozen", ref_code, tgt);
  endtask

  task automatic t_reset();
    check("R1 reset state", state, 0);
    check("R1 reset ref", ref_code, 0);
    check("R1 reset gates", {ugate_en, lgate_en}, 0);
    check("R1 reset pgood", pgood, 0);
  endtask

  task automatic t_partial_flags();
    mode = 2'b01; vid = 6'd40;
    for (int k = 0; k < 7; k++) begin
      flags(k[0], k[1], k[2]);
      cyc(); cyc();
      check("R2 partial flags stay off", state, 0);
      check("R1 gates low in shutdown", {ugate_en, lgate_en}, 0);
    end
    flags(0, 0, 0);
    cyc();
  endtask

  // 5-bit mode: no-load blocks start, bit 5 masked, ramp down to 40
  task automatic t_bit5_down();
    mode = 2'b10; vid = 6'h3F;
    flags(1, 1, 1);
    for (int i = 0; i < 8; i++) begin
      cyc();
      check("R3 no-load blocks start", state, 0);
    end
    vid = 6'h2A;
    cyc();
    check("R4 non-delayed goes to ramp1", state, 2);
    exp_ref = 0;
    ramp1_and_hold(4);
    ramp2_to(40);
    flags(1, 1, 0);
    cyc();
    check("R10 abort state", state, 0);
    check("R10 abort ref", ref_code, 0);
    check("R10 abort pgood", pgood, 0);
    flags(0, 0, 0);
    cyc();
  endtask

  task automatic t_delayed_up();
    mode = 2'b00; vid = 6'd50;
    flags(1, 1, 1);
    cyc();
    check("R2 start on all flags", state, 1);
    for (int i = 2; i <= DLY; i++) begin
      tick = (i % 2 == 0);
      cyc();
      check("R4 delay state", state, 1);
      check("R4 ref zero in delay", ref_code, 0);
    end
    tick = 1'b0;
    cyc();
    check("R4 delay ends in ramp1", state, 2);
    exp_ref = 0;
    ramp1_and_hold(4);
    ramp2_to(200);
    flags(1, 0, 1);
    cyc();
    check("R10 drv drop", state, 0);
    flags(0, 0, 0);
    cyc();
  endtask

  task automatic t_fault(input logic [1:0] m, input logic [5:0] v_start, input logic [5:0] v_hold);
    mode = m; vid = v_start;
    flags(1, 1, 1);
    cyc();
    exp_ref = 0;
    ramp_ticks(20, 1'b1, "R5 ramp1 step");
    vid = v_hold;
    ramp1_and_hold(6);
    check("R8 fault flag", fault, 1);
    check("R8 ref at boot", ref_code, BOOT);
    tick = 1'b1; cyc(); tick = 1'b0; cyc();
    check("R8 ref stays at boot", ref_code, BOOT);
    check("R8 no pgood", pgood, 0);
    flags(1, 0, 1);
    cyc();
    check("R10 fault cleared", fault, 0);
    check("R10 fault abort state", state, 0);
    flags(0, 0, 0);
    cyc();
  endtask

  // tick and flag loss in the same cycle: abort wins
  task automatic t_collision();
    mode = 2'b01; vid = 6'd40;
    flags(1, 1, 1);
    cyc();
    exp_ref = 0;
    ramp_ticks(10, 1'b1, "R5 ramp1 step");
    tick = 1'b1;
    bias_ok = 1'b0;
    cyc();
    tick = 1'b0;
    check("R10 abort beats tick ref", ref_code, 0);
    check("R10 abort beats tick state", state, 0);
    bias_ok = 1'b1;
    cyc();
    check("R2 restart after abort", state, 2);
    check("R1 ref restarts at zero", ref_code, 0);
    flags(0, 0, 0);
    cyc();
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_partial_flags();
    t_bit5_down();
    t_delayed_up();
    t_fault(2'b01, 6'd20, 6'd0);
    t_fault(2'b10, 6'd5, 6'h1F);
    t_collision();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule